// File: doc/BRIEF.md
# Six-Step Commutation Sequencer

This block keeps track of the commutation step of a three-phase brushless motor bridge. It turns the step into enables for the high-side and low-side switches of legs A, B and C. The step moves forward from three sources:

- a single-cycle zero-crossing pulse produced by the back-EMF comparator path;
- a single-cycle double-step pulse from the start-up mode controller, used to jump two steps during rotor alignment;
- rising edges of an external sequence-increment line, used when a supervisor drives start-up by hand.

When more than one source fires in the same cycle, their step counts are added. Every zero-crossing pulse toggles a spin-sense output. While the external increment line is high, zero-crossing pulses cannot move the step. Rising edges of that line that arrive too soon after the last accepted edge are ignored. Two override inputs put the bridge into a safe state without losing the step count. One turns every switch off. The other turns on all low sides for braking.

Top module: `commutation_sequencer`

## Requirements
- R1: After a synchronous active-low reset, phase_idx is 0 and spin_sense is 0.
- R2: With neither override active, the steps decode as follows. Bit 0 of hs_en and ls_en is leg A, bit 1 is leg B and bit 2 is leg C. Step 0 gives hs=001, ls=010. Step 1 gives hs=001, ls=100. Step 2 gives hs=010, ls=100. Step 3 gives hs=010, ls=001. Step 4 gives hs=100, ls=001. Step 5 gives hs=100, ls=010.
- R3: A zero_crossing pulse that is not masked advances phase_idx by one on the next clock edge. Step 5 wraps to step 0.
- R4: A double_step pulse advances phase_idx by two, modulo 6, on the next clock edge.
- R5: Each low-to-high transition of ext_incr advances phase_idx by one. Holding ext_incr high causes no further advance.
- R6: A rising edge of ext_incr is ignored when it comes fewer than GAP_CYCLES clock cycles after the last accepted edge. An edge exactly GAP_CYCLES cycles later is accepted. Ignored edges do not restart the spacing window.
- R7: While ext_incr is high, zero_crossing pulses do not advance phase_idx.
- R8: spin_sense toggles on every zero_crossing pulse, including masked ones, and holds otherwise.
- R9: Advances requested in the same cycle add together, modulo 6. For example, zero crossing plus double step gives three steps.
- R10: While tristate is high, hs_en and ls_en are all 0, whatever brake is.
- R11: While brake is high and tristate is low, ls_en is 111 and hs_en is 000. phase_idx keeps advancing under either override.
- R12: hs_en and ls_en are never both set on the same leg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| zero_crossing | input | 1 | One-cycle back-EMF zero-crossing pulse |
| double_step | input | 1 | One-cycle request to advance two steps |
| ext_incr | input | 1 | External sequence-increment level, already synchronized |
| tristate | input | 1 | Turn all bridge switches off |
| brake | input | 1 | Turn all low sides on, all high sides off |
| hs_en | output | 3 | High-side enables, bit 0 = A, bit 1 = B, bit 2 = C |
| ls_en | output | 3 | Low-side enables, bit 0 = A, bit 1 = B, bit 2 = C |
| phase_idx | output | 3 | Present commutation step, 0 to 5 |
| spin_sense | output | 1 | Toggles on every zero crossing |

## Verification
A walk of six zero crossings visits every step in turn, so it separates a wrong decode row from a wrong increment or a missing wrap. Repeated double steps from step 0 reach step 2 and step 4 and then wrap back to 0, which shows that the jump is two steps and not one or three. The external-increment pattern holds the line high, lowers it, and then raises it 4, 10 and 9 cycles after the last accepted edge. This tells a level-triggered increment apart from an edge-triggered one, and it tests both sides of the spacing window. Coincident requests and the two overrides, with zero crossings arriving while an override is active, show whether requests are added or prioritized. They also show whether the overrides freeze the step.

// File: rtl/comm_seq_pkg.sv
// Package: types and helpers shared by the commutation sequencer.
// Assumes six commutation steps, numbered 0 to 5, and a three-leg bridge
// whose leg bits are ordered A (bit 0), B (bit 1), C (bit 2).
package comm_seq_pkg;

    localparam int NUM_STEPS = 6;
    localparam int NUM_LEGS  = 3;

    typedef logic [2:0]          step_t;
    typedef logic [NUM_LEGS-1:0] leg_mask_t;

    typedef struct packed {
        leg_mask_t hs;
        leg_mask_t ls;
    } drive_t;

    // Adds an advance of 0..4 steps to a step, modulo NUM_STEPS.
    function automatic step_t step_add(step_t cur, logic [2:0] amount);
        logic [3:0] sum;
        sum = {1'b0, cur} + {1'b0, amount};
        if (sum >= 4'(NUM_STEPS)) sum = sum - 4'(NUM_STEPS);
        return sum[2:0];
    endfunction

    // Maps a step to the legs driven high and driven low.
    function automatic drive_t step_drive(step_t s);
        drive_t d;
        case (s)
            3'd0:    d = '{hs: 3'b001, ls: 3'b010};
            3'd1:    d = '{hs: 3'b001, ls: 3'b100};
            3'd2:    d = '{hs: 3'b010, ls: 3'b100};
            3'd3:    d = '{hs: 3'b010, ls: 3'b001};
            3'd4:    d = '{hs: 3'b100, ls: 3'b001};
            3'd5:    d = '{hs: 3'b100, ls: 3'b010};
            default: d = '{hs: 3'b000, ls: 3'b000};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/ext_step_gate.sv
// Module: ext_step_gate
// Turns the external increment level into a single-cycle step pulse on each
// rising edge. A rising edge is accepted only when at least GAP_CYCLES
// cycles have passed since the last accepted one.
// Assumes ext_incr is already synchronous to clk. GAP_CYCLES is at least 1.
module ext_step_gate #(
    parameter int GAP_CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_incr,
    output logic step_o
);
    localparam int CW = $clog2(GAP_CYCLES + 1);

    logic          ext_prev;
    logic [CW-1:0] hold_cnt;
    logic          rise;

    assign rise   = ext_incr & ~ext_prev;
    assign step_o = rise & (hold_cnt == '0);

    // Keep the previous level of the line so that edges can be found.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_prev <= 1'b0;
        else        ext_prev <= ext_incr;
    end

    // Count down the spacing window that starts at each accepted edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                hold_cnt <= '0;
        else if (step_o)           hold_cnt <= CW'(GAP_CYCLES - 1);
        else if (hold_cnt != '0)   hold_cnt <= hold_cnt - 1'b1;
    end
endmodule

// File: rtl/phase_counter.sv
// Module: phase_counter
// Holds the commutation step and advances it by the sum of all requests
// seen in a cycle: one for a zero crossing, one for an external step and
// two for a double step. The result wraps modulo six.
// Assumes each request input is a single-cycle pulse.
module phase_counter
    import comm_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  zc_step,
    input  logic  ext_step,
    input  logic  dbl_step,
    output step_t phase_o
);
    logic [2:0] amount;
    step_t      phase_q;

    // Add up the step requests of this cycle.
    always_comb begin
        amount = {dbl_step, 1'b0} + {2'b00, zc_step} + {2'b00, ext_step};
    end

    // Register the step, starting from step 0 after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= step_add(phase_q, amount);
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/drive_decoder.sv
// Module: drive_decoder
// Decodes the step into per-leg switch enables and applies the overrides.
// Tristate turns every switch off and takes priority over brake. Brake
// turns on every low side.
// Assumes the step is in the range 0..5. Other values give all switches off.
module drive_decoder
    import comm_seq_pkg::*;
(
    input  step_t     phase,
    input  logic      tristate,
    input  logic      brake,
    output leg_mask_t hs_en,
    output leg_mask_t ls_en
);
    drive_t base;

    // Look up the normal drive pattern for the present step.
    always_comb base = step_drive(phase);

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        // Apply the overrides to one leg.
        always_comb begin
            if (tristate) begin
                hs_en[g] = 1'b0;
                ls_en[g] = 1'b0;
            end else if (brake) begin
                hs_en[g] = 1'b0;
                ls_en[g] = 1'b1;
            end else begin
                hs_en[g] = base.hs[g];
                ls_en[g] = base.ls[g];
            end
        end
    end
endmodule

// File: rtl/commutation_sequencer.sv
// Module: commutation_sequencer (top)
// Six-step commutation sequencer. It takes zero-crossing, double-step and
// external-increment requests, masks zero crossings while the external line
// is high, toggles spin_sense on every zero crossing, and drives the bridge
// enables with the tristate and brake overrides applied.
// Assumes every input is synchronous to clk.
module commutation_sequencer
    import comm_seq_pkg::*;
#(
    parameter int GAP_CYCLES = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       zero_crossing,
    input  logic       double_step,
    input  logic       ext_incr,
    input  logic       tristate,
    input  logic       brake,
    output logic [2:0] hs_en,
    output logic [2:0] ls_en,
    output logic [2:0] phase_idx,
    output logic       spin_sense
);
    logic  ext_step;
    logic  zc_step;
    logic  spin_q;
    step_t phase;

    // Ignore zero crossings while the external increment line is high.
    assign zc_step = zero_crossing & ~ext_incr;

    ext_step_gate #(.GAP_CYCLES(GAP_CYCLES)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_incr (ext_incr),
        .step_o   (ext_step)
    );

    phase_counter u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .zc_step  (zc_step),
        .ext_step (ext_step),
        .dbl_step (double_step),
        .phase_o  (phase)
    );

    drive_decoder u_dec (
        .phase    (phase),
        .tristate (tristate),
        .brake    (brake),
        .hs_en    (hs_en),
        .ls_en    (ls_en)
    );

    // Toggle the spin indicator on every zero crossing, masked or not.
    always_ff @(posedge clk) begin
        if (!rst_n)             spin_q <= 1'b0;
        else if (zero_crossing) spin_q <= ~spin_q;
    end

    assign phase_idx  = phase;
    assign spin_sense = spin_q;
endmodule

// File: rtl/commutation_sequencer_checker.sv
// Module: commutation_sequencer_checker
// Assertions for commutation_sequencer, attached to it with a bind.
// Assumes the same GAP_CYCLES as the bound instance.
module commutation_sequencer_checker #(
    parameter int GAP_CYCLES = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       zero_crossing,
    input logic       double_step,
    input logic       ext_incr,
    input logic       ext_step,
    input logic       tristate,
    input logic       brake,
    input logic [2:0] hs_en,
    input logic [2:0] ls_en,
    input logic [2:0] phase_idx,
    input logic       spin_sense
);
    localparam int SW = $clog2(GAP_CYCLES + 1);

    logic [SW-1:0] since_step;

    // Count the cycles since the last accepted external step, stopping at GAP_CYCLES.
    always_ff @(posedge clk) begin
        if (!rst_n)                          since_step <= SW'(GAP_CYCLES);
        else if (ext_step)                   since_step <= SW'(1);
        else if (since_step < SW'(GAP_CYCLES)) since_step <= since_step + 1'b1;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (phase_idx == 3'd0 && spin_sense == 1'b0));

    p_step_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_idx < 3'd6);

    p_zc_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_crossing && !ext_incr && !double_step) |=>
        (phase_idx == (($past(phase_idx) == 3'd5) ? 3'd0 : $past(phase_idx) + 3'd1)));

    p_double_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (double_step && !zero_crossing && !ext_incr) |=>
        (phase_idx == (($past(phase_idx) >= 3'd4) ? $past(phase_idx) - 3'd4
                                                  : $past(phase_idx) + 3'd2)));

    p_ext_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ext_step |-> (since_step >= SW'(GAP_CYCLES)));

    p_zc_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_incr && !ext_step && !double_step) |=> $stable(phase_idx));

    p_spin_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        zero_crossing |=> (spin_sense != $past(spin_sense)));

    p_spin_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_crossing |=> $stable(spin_sense));

    p_tristate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tristate |-> (hs_en == 3'b000 && ls_en == 3'b000));

    p_brake_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (brake && !tristate) |-> (hs_en == 3'b000 && ls_en == 3'b111));

    p_leg_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en & ls_en) == 3'b000);

    p_one_hot_run_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!tristate && !brake) |-> ($countones(hs_en) == 1 && $countones(ls_en) == 1));
endmodule

bind commutation_sequencer commutation_sequencer_checker #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .zero_crossing (zero_crossing),
    .double_step   (double_step),
    .ext_incr      (ext_incr),
    .ext_step      (ext_step),
    .tristate      (tristate),
    .brake         (brake),
    .hs_en         (hs_en),
    .ls_en         (ls_en),
    .phase_idx     (phase_idx),
    .spin_sense    (spin_sense)
);

// File: tb/commutation_sequencer_bench.sv
// Directed bench for commutation_sequencer. Inputs change just after the
// falling edge and outputs are sampled at the falling edge.
module commutation_sequencer_bench;
    localparam int GAP = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       zero_crossing = 1'b0;
    logic       double_step = 1'b0;
    logic       ext_incr = 1'b0;
    logic       tristate = 1'b0;
    logic       brake = 1'b0;
    logic [2:0] hs_en;
    logic [2:0] ls_en;
    logic [2:0] phase_idx;
    logic       spin_sense;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;
    logic [2:0] exp_ph   = 3'd0;
    logic       exp_spin = 1'b0;

    always #5 clk = ~clk;

    commutation_sequencer #(.GAP_CYCLES(GAP)) u_commutation_sequencer (
        .clk           (clk),
        .rst_n         (rst_n),
        .zero_crossing (zero_crossing),
        .double_step   (double_step),
        .ext_incr      (ext_incr),
        .tristate      (tristate),
        .brake         (brake),
        .hs_en         (hs_en),
        .ls_en         (ls_en),
        .phase_idx     (phase_idx),
        .spin_sense    (spin_sense)
    );

    function automatic logic [5:0] expect_drive(logic [2:0] ph, logic tri_s, logic brk);
        if (tri_s) return 6'b000_000;
        if (brk)   return 6'b000_111;
        case (ph)
            3'd0: return 6'b001_010;
            3'd1: return 6'b001_100;
            3'd2: return 6'b010_100;
            3'd3: return 6'b010_001;
            3'd4: return 6'b100_001;
            3'd5: return 6'b100_010;
            default: return 6'b000_000;
        endcase
    endfunction

    function automatic logic [2:0] add6(logic [2:0] a, int n);
        return 3'((int'(a) + n) % 6);
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Compare every output with the tracked expectations.
    task automatic check_all(string req);
        logic [5:0] d;
        d = expect_drive(exp_ph, tristate, brake);
        check({req, " phase"}, int'(phase_idx), int'(exp_ph));
        check({req, " spin"},  int'(spin_sense), int'(exp_spin));
        check({req, " hs/ls"}, int'({hs_en, ls_en}), int'(d));
        check({req, " R12 leg clash"}, int'(hs_en & ls_en), 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_ph = 3'd0; exp_spin = 1'b0;
        check_all("R1 reset");
    endtask

    // R2 R3 R8: six zero crossings walk through every step and wrap.
    task automatic t_zc_walk;
        for (int i = 0; i < 6; i++) begin
            zero_crossing = 1'b1;
            @(negedge clk);
            zero_crossing = 1'b0;
            exp_ph = add6(exp_ph, 1); exp_spin = ~exp_spin;
            check_all("R2 R3 R8 zc walk");
        end
        @(negedge clk);
        check_all("R8 spin hold");
    endtask

    // R4: double steps reach 2 (B high, C low), 4, then wrap to 0.
    task automatic t_double;
        for (int i = 0; i < 3; i++) begin
            double_step = 1'b1;
            @(negedge clk);
            double_step = 1'b0;
            exp_ph = add6(exp_ph, 2);
            check_all("R4 double step");
        end
    endtask

    // R5 R6 R7: the external line is edge-triggered, spaced, and masks zero crossings.
    task automatic t_ext;
        ext_incr = 1'b1;
        @(negedge clk);                       // accepted edge, P0
        exp_ph = add6(exp_ph, 1);
        check_all("R5 ext rise");
        zero_crossing = 1'b1;
        @(negedge clk);                       // P1, line still high
        zero_crossing = 1'b0;
        exp_spin = ~exp_spin;
        check_all("R5 R7 held high masks zc");
        ext_incr = 1'b0;
        repeat (2) @(negedge clk);
        ext_incr = 1'b1;
        @(negedge clk);                       // rise at P4, too soon
        check_all("R6 edge 4 cycles after");
        ext_incr = 1'b0;
        repeat (5) @(negedge clk);
        ext_incr = 1'b1;
        @(negedge clk);                       // rise at P10, accepted
        exp_ph = add6(exp_ph, 1);
        check_all("R6 edge exactly GAP after");
        ext_incr = 1'b0;
        repeat (8) @(negedge clk);
        ext_incr = 1'b1;
        @(negedge clk);                       // rise 9 cycles later, ignored
        check_all("R6 edge GAP-1 after");
        ext_incr = 1'b0;
        repeat (GAP + 2) @(negedge clk);
        check_all("R5 line low");
    endtask

    // R9: requests in one cycle add together.
    task automatic t_combined;
        zero_crossing = 1'b1; double_step = 1'b1;
        @(negedge clk);
        exp_ph = add6(exp_ph, 3); exp_spin = ~exp_spin;
        check_all("R9 zc+double");
        @(negedge clk);
        exp_ph = add6(exp_ph, 3); exp_spin = ~exp_spin;
        check_all("R9 zc+double wrap");
        ext_incr = 1'b1;
        @(negedge clk);
        zero_crossing = 1'b0; double_step = 1'b0;
        exp_ph = add6(exp_ph, 3); exp_spin = ~exp_spin;
        check_all("R9 R7 ext+double, zc masked");
        ext_incr = 1'b0;
        @(negedge clk);
        check_all("R9 settle");
    endtask

    // R10 R11: the overrides gate the drive while the step keeps moving.
    task automatic t_override;
        tristate = 1'b1; brake = 1'b1;
        #1;
        check_all("R10 tristate over brake");
        zero_crossing = 1'b1;
        @(negedge clk);
        zero_crossing = 1'b0;
        exp_ph = add6(exp_ph, 1); exp_spin = ~exp_spin;
        check_all("R10 step advances under tristate");
        tristate = 1'b0;
        #1;
        check_all("R11 brake");
        double_step = 1'b1;
        @(negedge clk);
        double_step = 1'b0;
        exp_ph = add6(exp_ph, 2);
        check_all("R11 step advances under brake");
        brake = 1'b0;
        #1;
        check_all("R11 release brake");
    endtask

    initial begin
        t_reset();
        t_zc_walk();
        t_double();
        t_ext();
        t_combined();
        t_override();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule